// File: doc/BRIEF.md
# Adaptive Mark/Space Amplitude Slicer

This block sits behind a carrier amplitude estimator in a receiver for a slow amplitude-modulated time code. Once per carrier cycle it is handed an unsigned amplitude figure. It decides whether that cycle belongs to the strong (mark) part of a symbol or the weak (space) part. Mark cycles are nominally about three times as strong as space cycles. A pattern matcher further down the chain uses the resulting one-bit stream.

The slicing level follows the strong cycles only. A first-order recursive average `lvl += (amp - lvl) * 2^-k` is updated with cycles that the block has already judged strong. The threshold is then held at two thirds of that average. Because of this, the uneven mark/space duty of the pulse-width symbols does not bias the threshold. The gain starts large (k = 4) so that the first lock is quick. It falls to a small value (k = 7) after a run of updates that all land close to the average. With k = 7, a 10 % step in the mean needs on the order of a thousand cycles to work through.

The very first sample after reset only seeds the threshold at half its own value. The first strong cycle after that loads the average directly.

Top module: `amp_level_tracker`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `bit_valid_o` and `bit_high_o` are 0, `threshold_o` is 0 and `acquiring_o` is 1.
- R2: A sample presented with `amp_valid_i` high yields, on the next clock, `bit_valid_o` = 1 and `bit_high_o` = 1 exactly when `amp_i` is strictly greater than the `threshold_o` shown in the sample's own cycle. In a cycle after no valid sample, both outputs are 0.
- R3: The first valid sample after reset is reported low, and it sets `threshold_o` to floor(amp / 2).
- R4: The first sample reported high loads the average with that amplitude and sets `threshold_o` to floor(2 * amp / 3).
- R5: Every later high sample moves the average, which has FRAC_W fraction bits, by (amp - average) arithmetically shifted right by k, rounded toward minus infinity. `threshold_o` becomes the integer part of two thirds of the new average (the doubled average divided by 3, rounded down).
- R6: A sample reported low leaves `threshold_o` and the average unchanged.
- R7: k is ACQ_SHIFT (4) while `acquiring_o` is 1 and TRK_SHIFT (7) once it is 0. The update that ends acquisition still uses ACQ_SHIFT.
- R8: An update counts as close when |amp - average| < average / 8, with both taken before the update. `acquiring_o` falls together with the LOCK_RUN-th consecutive close update. An update that is not close restarts the run. `acquiring_o` never returns to 1 until reset.
- R9: `threshold_o` does not change on a clock where `amp_valid_i` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| amp_valid_i | input | 1 | A carrier-cycle amplitude is present |
| amp_i | input | AMP_W | Unsigned amplitude of the cycle |
| bit_valid_o | output | 1 | A decision is present (registered) |
| bit_high_o | output | 1 | The cycle was judged a mark cycle |
| threshold_o | output | AMP_W | Current slicing level |
| acquiring_o | output | 1 | Fast-gain mode is active |

## Verification
The bench keeps the default 12-bit amplitude, 8 fraction bits and both default shifts. It lowers LOCK_RUN to 16, so the change from fast to slow gain happens early in the run, and most of the random stimulus then exercises the slow-gain arithmetic. Directed outliers placed among close updates break the run of close updates. This shows that the counter restarts and that the mode change is pushed later by the matching number of updates. Idle gaps are mixed in to show that the level holds while no samples arrive.

// File: rtl/amp_trk_pkg.sv
package amp_trk_pkg;
  // Absolute difference of two unsigned values of equal width.
  function automatic logic [31:0] abs_diff32(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/amp_trk_filter.sv
module amp_trk_filter #(
  parameter int AMP_W     = 12,
  parameter int FRAC_W    = 8,
  parameter int ACQ_SHIFT = 4,
  parameter int TRK_SHIFT = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_i,
  input  logic                      upd_i,
  input  logic                      fast_i,
  input  logic [AMP_W-1:0]          amp_i,
  output logic [AMP_W+FRAC_W-1:0]   level_o,
  output logic [AMP_W-1:0]          thr_next_o
);
  localparam int LVL_W = AMP_W + FRAC_W;

  logic [LVL_W-1:0]        level_q, level_d, amp_full;
  logic signed [LVL_W+1:0] diff, step, sum;
  logic [LVL_W:0]          dbl, third;

  assign amp_full = {amp_i, {FRAC_W{1'b0}}};
  assign diff     = $signed({2'b00, amp_full}) - $signed({2'b00, level_q});

  always_comb begin
    if (fast_i) step = diff >>> ACQ_SHIFT;
    else        step = diff >>> TRK_SHIFT;
    sum     = $signed({2'b00, level_q}) + step;
    level_d = load_i ? amp_full : sum[LVL_W-1:0];
    dbl     = {level_d, 1'b0};
    third   = dbl / (LVL_W+1)'(3);
  end

  assign thr_next_o = third[FRAC_W +: AMP_W];
  assign level_o    = level_q;

  always_ff @(posedge clk) begin
    if (rst)                  level_q <= '0;
    else if (load_i || upd_i) level_q <= level_d;
  end
endmodule

// File: rtl/amp_trk_lock.sv
module amp_trk_lock #(
  parameter int AMP_W     = 12,
  parameter int FRAC_W    = 8,
  parameter int ERR_SHIFT = 3,
  parameter int LOCK_RUN  = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_i,
  input  logic [AMP_W-1:0]        amp_i,
  input  logic [AMP_W+FRAC_W-1:0] level_i,
  output logic                    acquiring_o
);
  import amp_trk_pkg::*;
  localparam int LVL_W = AMP_W + FRAC_W;
  localparam int CNT_W = (LOCK_RUN > 2) ? $clog2(LOCK_RUN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_RUN - 1);

  logic [LVL_W-1:0] amp_full, err;
  logic             close;
  logic [CNT_W-1:0] run_q;

  assign amp_full = {amp_i, {FRAC_W{1'b0}}};
  assign err      = LVL_W'(abs_diff32(32'(amp_full), 32'(level_i)));
  assign close    = err < (level_i >> ERR_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      acquiring_o <= 1'b1;
      run_q       <= '0;
    end else if (upd_i && acquiring_o) begin
      if (close) begin
        if (run_q == LAST) acquiring_o <= 1'b0;
        run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/amp_level_tracker.sv
module amp_level_tracker #(
  parameter int AMP_W     = 12,
  parameter int FRAC_W    = 8,
  parameter int ACQ_SHIFT = 4,
  parameter int TRK_SHIFT = 7,
  parameter int ERR_SHIFT = 3,
  parameter int LOCK_RUN  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             amp_valid_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic             bit_valid_o,
  output logic             bit_high_o,
  output logic [AMP_W-1:0] threshold_o,
  output logic             acquiring_o
);
  localparam int LVL_W = AMP_W + FRAC_W;

  logic             seeded_q, have_lvl_q;
  logic             is_high, load, upd;
  logic [LVL_W-1:0] level;
  logic [AMP_W-1:0] thr_next;

  assign is_high = seeded_q && (amp_i > threshold_o);
  assign load    = amp_valid_i && is_high && !have_lvl_q;
  assign upd     = amp_valid_i && is_high && have_lvl_q;

  amp_trk_filter #(
    .AMP_W(AMP_W), .FRAC_W(FRAC_W), .ACQ_SHIFT(ACQ_SHIFT), .TRK_SHIFT(TRK_SHIFT)
  ) filt_i (
    .clk(clk), .rst(rst), .load_i(load), .upd_i(upd), .fast_i(acquiring_o),
    .amp_i(amp_i), .level_o(level), .thr_next_o(thr_next)
  );

  amp_trk_lock #(
    .AMP_W(AMP_W), .FRAC_W(FRAC_W), .ERR_SHIFT(ERR_SHIFT), .LOCK_RUN(LOCK_RUN)
  ) lock_i (
    .clk(clk), .rst(rst), .upd_i(upd), .amp_i(amp_i), .level_i(level),
    .acquiring_o(acquiring_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_valid_o <= 1'b0;
      bit_high_o  <= 1'b0;
      threshold_o <= '0;
      seeded_q    <= 1'b0;
      have_lvl_q  <= 1'b0;
    end else begin
      bit_valid_o <= amp_valid_i;
      bit_high_o  <= amp_valid_i && is_high;
      if (amp_valid_i) begin
        if (!seeded_q) begin
          threshold_o <= amp_i >> 1;
          seeded_q    <= 1'b1;
        end else if (is_high) begin
          threshold_o <= thr_next;
          have_lvl_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/amp_level_tracker_chk.sv
module amp_level_tracker_chk #(
  parameter int AMP_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             amp_valid_i,
  input logic             bit_valid_o,
  input logic             bit_high_o,
  input logic [AMP_W-1:0] threshold_o,
  input logic             acquiring_o
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (bit_valid_o == $past(amp_valid_i))); // R2
  AST_HIGH_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    bit_high_o |-> bit_valid_o); // R2
  AST_THR_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(amp_valid_i)) |-> $stable(threshold_o)); // R9
  AST_NO_REACQUIRE: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> !$rose(acquiring_o)); // R8
  AST_ACQ_EXIT_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $fell(acquiring_o)) |-> bit_high_o); // R8
endmodule

bind amp_level_tracker amp_level_tracker_chk #(.AMP_W(AMP_W)) chk_i (
  .clk(clk), .rst(rst), .amp_valid_i(amp_valid_i), .bit_valid_o(bit_valid_o),
  .bit_high_o(bit_high_o), .threshold_o(threshold_o), .acquiring_o(acquiring_o)
);

// File: tb/amp_level_tracker_tb_top.sv
module amp_level_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AMP_W      = 12;
  localparam int FRAC_W     = 8;
  localparam int LOCK_RUN   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic amp_valid_i = 1'b0;
  logic [AMP_W-1:0] amp_i = '0;
  logic bit_valid_o, bit_high_o, acquiring_o;
  logic [AMP_W-1:0] threshold_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  bit     m_seeded, m_have, m_acq;
  longint m_level, m_thr;
  int     m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  amp_level_tracker #(.AMP_W(AMP_W), .FRAC_W(FRAC_W), .LOCK_RUN(LOCK_RUN)) dut_i (
    .clk(clk), .rst(rst), .amp_valid_i(amp_valid_i), .amp_i(amp_i),
    .bit_valid_o(bit_valid_o), .bit_high_o(bit_high_o),
    .threshold_o(threshold_o), .acquiring_o(acquiring_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_seeded = 0; m_have = 0; m_acq = 1; m_level = 0; m_thr = 0; m_cnt = 0;
  endtask

  // R3 R4 R5 R6 R7 R8: expected decision and state update for one sample
  function automatic bit model_step(input longint a);
    longint full, err, diff, step;
    bit     close, hi;
    int     sh;
    hi = 0;
    if (!m_seeded) begin
      m_thr = a / 2; m_seeded = 1;
    end else if (a > m_thr) begin
      hi = 1;
      full = a <<< FRAC_W;
      if (!m_have) begin
        m_level = full; m_have = 1;
      end else begin
        err   = (full > m_level) ? full - m_level : m_level - full;
        close = err < (m_level >>> 3);
        sh    = m_acq ? 4 : 7;
        diff  = full - m_level;
        step  = diff >>> sh;
        if (m_acq) begin
          if (close) begin
            if (m_cnt == LOCK_RUN-1) m_acq = 0;
            m_cnt++;
          end else m_cnt = 0;
        end
        m_level = m_level + step;
      end
      m_thr = ((m_level * 2) / 3) >>> FRAC_W;
    end
    return hi;
  endfunction

  task automatic send(input int a);
    bit e_hi;
    @(negedge clk);
    amp_valid_i = 1'b1;
    amp_i = a[AMP_W-1:0];
    e_hi = model_step(longint'(a));
    @(posedge clk); #1;
    amp_valid_i = 1'b0;
    check("R2 valid", bit_valid_o, 1);
    check("R2/R6 decision", bit_high_o, e_hi);
    check("R3/R4/R5 threshold", threshold_o, m_thr);
    check("R7/R8 acquiring", acquiring_o, m_acq);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); amp_valid_i = 1'b0;
      @(posedge clk); #1;
      check("R2 no valid", bit_valid_o, 0);
      check("R9 threshold hold", threshold_o, m_thr);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int r;
    r = $urandom(32'h5eed_1234);
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", bit_valid_o, 0);
    check("R1 high", bit_high_o, 0);
    check("R1 threshold", threshold_o, 0);
    check("R1 acquiring", acquiring_o, 1);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 after", threshold_o, 0);

    send(1001);          // R3 seed -> 500, low
    send(400);           // R6 low, no change
    send(1500);          // R4 load, thr 1000
    idle(3);             // R9
    send(1520);          // R5 fast update
    send(999);           // R6 equal-ish below threshold
    send(1013);          // R2 strict compare boundary near thr
    // R8: close run broken by an outlier
    for (int i = 0; i < 10; i++) send(1500 + (i % 3) * 10);
    send(3000);          // not close: restarts run
    for (int i = 0; i < 20; i++) send(1490 + (i % 5) * 5);
    // random mark/space traffic, mostly in slow gain (R5 R7)
    for (int i = 0; i < 3000; i++) begin
      int sel, amp;
      sel = $urandom_range(0, 9);
      if (sel < 4)      amp = 1500 + $urandom_range(0, 120) - 60;
      else if (sel < 9) amp = 500 + $urandom_range(0, 120) - 60;
      else              amp = $urandom_range(0, 4095);
      if ($urandom_range(0, 7) == 0) idle(1);
      send(amp);
    end
    // extremes
    send(4095);
    send(0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule